// File: doc/BRIEF.md
# Small-subset 32-bit MIPS core

A single-cycle processor that executes a fixed set of thirteen 32-bit MIPS instruction words. Every instruction completes in one clock. The program counter advances, the register file and the multiply product register update, and a store reaches the data memory port, all on the same rising edge. Both memories sit outside the core and are read combinationally. The instruction port takes a word address, and the instruction word comes back in the same cycle. The data port presents a byte address, write data and a write strobe, and it accepts read data in the same cycle.

The top 6 bits of each word are the opcode. Register fields are 5 bits: rs in bits 25:21, rt in 20:16 and rd in 15:11. Register-register operations carry opcode 000000 and a function code in bits 5:0. Immediate forms carry a 16-bit immediate in bits 15:0. Jump forms carry a 26-bit target in bits 25:0. An opcode or function code outside the set does nothing except move the program counter on by one word.

Top module: `mips_lite_core`

## Requirements
- R1: While rst_n is low, the core holds the instruction word address at 0, keeps dmem_we low even if the fetched word is a store, and clears all registers and the product register.
- R2: Every instruction that is not a branch or a jump advances the instruction word address by exactly one per clock.
- R3: lw (opcode 100011) and sw (opcode 101011) form the byte address rs + sign-extended imm. lw loads that word into rt. sw drives rt on dmem_wdata with dmem_we high for that one cycle. dmem_we is high only for sw.
- R4: addi (opcode 001000) writes rs + sign-extended 16-bit immediate into rt.
- R5: add (function 100000) and sub (function 100010) write rs+rt and rs-rt, modulo 2^32, into rd.
- R6: slt (function 101010) writes 1 to rd when rs < rt as signed values, and writes 0 otherwise, including when the two are equal.
- R7: mult (opcode 000000, function 011000) stores the low 32 bits of the signed product rs*rt in a product register and writes no general register. mflo (function 010010) copies that register into rd.
- R8: beq (000100) and bne (000101) compare rs with rt. When the branch is taken, the next address is PC+4 plus the sign-extended immediate shifted left by 2, and the immediate may be negative. When the branch is not taken, the next address is PC+4.
- R9: j (000010) and jal (000011) go to {PC+4[31:28], target, 00}. jal also writes PC+4 into register 31.
- R10: jr (function 001000) loads the program counter from rs.
- R11: Register 0 ignores every write and always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | IMEM_AW | Word address of the instruction being executed |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per sw |
| dmem_rdata | input | 32 | Load data at dmem_addr |

## Verification
The bench builds the core with IMEM_AW = 8 and RESET_PC = 0, and attaches 256-word behavioural memories. Every program therefore fits in a small word range, and jump targets map directly onto the low target bits. Results come out only through sw, so each scenario ends by storing its registers and then compares the bench's data memory with values worked out from the requirements. The cases include a negative immediate, a backward loop branch, a 32x32 product that overflows, signed comparison across zero, and writes aimed at register 0.

// File: rtl/mips_lite_core.sv
module mips_lite_core #(
  parameter int          IMEM_AW  = 10,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [31:0]        imem_data,
  output logic [31:0]        dmem_addr,
  output logic [31:0]        dmem_wdata,
  output logic               dmem_we,
  input  logic [31:0]        dmem_rdata
);
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_JAL   = 6'b000011;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;
  localparam logic [5:0] FN_SLT   = 6'b101010;
  localparam logic [5:0] FN_MFLO  = 6'b010010;
  localparam logic [5:0] FN_JR    = 6'b001000;
  localparam logic [5:0] FN_MULT  = 6'b011000;
  localparam logic [4:0] LINK_REG = 5'd31;

  logic [31:0] pc, pc_next, pc_plus4;
  logic [31:0] rf [32];
  logic [31:0] lo_q;

  wire [5:0]  opc   = imem_data[31:26];
  wire [4:0]  f_rs  = imem_data[25:21];
  wire [4:0]  f_rt  = imem_data[20:16];
  wire [4:0]  f_rd  = imem_data[15:11];
  wire [5:0]  funct = imem_data[5:0];
  wire [31:0] simm  = {{16{imem_data[15]}}, imem_data[15:0]};
  wire [31:0] a_val = (f_rs == 5'd0) ? 32'h0 : rf[f_rs];
  wire [31:0] b_val = (f_rt == 5'd0) ? 32'h0 : rf[f_rt];
  wire signed [63:0] product = $signed(a_val) * $signed(b_val);
  wire is_mult = (opc == OP_RTYPE) && (funct == FN_MULT);

  assign pc_plus4   = pc + 32'd4;
  assign imem_addr  = pc[IMEM_AW+1:2];
  assign dmem_addr  = a_val + simm;
  assign dmem_wdata = b_val;
  assign dmem_we    = rst_n && (opc == OP_SW);

  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_val;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = f_rt;
    wr_val = a_val + simm;
    case (opc)
      OP_RTYPE: begin
        wr_idx = f_rd;
        case (funct)
          FN_ADD:  begin wr_en = 1'b1; wr_val = a_val + b_val; end
          FN_SUB:  begin wr_en = 1'b1; wr_val = a_val - b_val; end
          FN_SLT:  begin wr_en = 1'b1; wr_val = {31'h0, $signed(a_val) < $signed(b_val)}; end
          FN_MFLO: begin wr_en = 1'b1; wr_val = lo_q; end
          default: wr_en = 1'b0;
        endcase
      end
      OP_ADDI: wr_en = 1'b1;
      OP_LW:   begin wr_en = 1'b1; wr_val = dmem_rdata; end
      OP_JAL:  begin wr_en = 1'b1; wr_idx = LINK_REG; wr_val = pc_plus4; end
      default: wr_en = 1'b0;
    endcase
  end

  always_comb begin
    pc_next = pc_plus4;
    case (opc)
      OP_BEQ:   if (a_val == b_val) pc_next = pc_plus4 + {simm[29:0], 2'b00};
      OP_BNE:   if (a_val != b_val) pc_next = pc_plus4 + {simm[29:0], 2'b00};
      OP_J,
      OP_JAL:   pc_next = {pc_plus4[31:28], imem_data[25:0], 2'b00};
      OP_RTYPE: if (funct == FN_JR) pc_next = a_val;
      default:  pc_next = pc_plus4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= RESET_PC;
      lo_q <= 32'h0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'h0;
    end else begin
      pc <= pc_next;
      if (is_mult) lo_q <= product[31:0];
      if (wr_en && wr_idx != 5'd0) rf[wr_idx] <= wr_val;
    end
  end
endmodule

module mips_lite_core_chk #(
  parameter int IMEM_AW = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IMEM_AW-1:0] imem_addr,
  input logic [31:0]        imem_data,
  input logic [31:0]        dmem_wdata,
  input logic               dmem_we
);
  wire [5:0] c_op = imem_data[31:26];
  wire c_jr   = (c_op == 6'b000000) && (imem_data[5:0] == 6'b001000);
  wire c_jump = (c_op == 6'b000010) || (c_op == 6'b000011);
  wire c_flow = c_jump || c_jr || (c_op == 6'b000100) || (c_op == 6'b000101);

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !c_flow |=> imem_addr == IMEM_AW'($past(imem_addr) + 1'b1));

  assert_store_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> c_op == 6'b101011);

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    c_jump |=> imem_addr == $past(imem_data[IMEM_AW-1:0]));

  assert_zero_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_we && imem_data[20:16] == 5'd0) |-> dmem_wdata == 32'h0);
endmodule

bind mips_lite_core mips_lite_core_chk #(.IMEM_AW(IMEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_wdata(dmem_wdata), .dmem_we(dmem_we));

// File: tb/mips_lite_core_test.sv
module mips_lite_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, ADDI = 6'b001000;
  localparam logic [5:0] BEQ = 6'b000100, BNE = 6'b000101, J = 6'b000010, JAL = 6'b000011;
  localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010, F_SLT = 6'b101010;
  localparam logic [5:0] F_MFLO = 6'b010010, F_JR = 6'b001000, F_MULT = 6'b011000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [31:0] imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;
  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mips_lite_core #(.IMEM_AW(AW), .RESET_PC(32'h0)) uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata));

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input int imm);
    return {op, rs, rt, 16'(imm)};
  endfunction
  function automatic logic [31:0] rr(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] fn);
    return {6'b0, rs, rt, rd, 5'b0, fn};
  endfunction
  function automatic logic [31:0] jj(input logic [5:0] op, input int tgt);
    return {op, 26'(tgt)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mems;
    for (int i = 0; i < 256; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
  endtask

  task automatic start_run(input int cycles);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic test_reset;
    clear_mems();
    dmem[0] = 32'h0000005A;
    imem[0] = ri(SW, 5'd0, 5'd0, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 addr in reset", 32'(imem_addr), 32'h0);
    check("R1 we in reset", 32'(dmem_we), 32'h0);
    check("R1 no store in reset", dmem[0], 32'h0000005A);
    imem[0] = 32'h0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 sequential advance", 32'(imem_addr), 32'd3);
  endtask

  task automatic test_arith;
    clear_mems();
    imem[0] = ri(ADDI, 5'd0, 5'd8, 5000);
    imem[1] = ri(ADDI, 5'd0, 5'd9, -3);
    imem[2] = rr(5'd8, 5'd9, 5'd10, F_ADD);
    imem[3] = rr(5'd9, 5'd8, 5'd11, F_SUB);
    imem[4] = ri(SW, 5'd0, 5'd10, 0);
    imem[5] = ri(SW, 5'd0, 5'd11, 4);
    imem[6] = ri(SW, 5'd0, 5'd9, 8);
    imem[7] = ri(SW, 5'd0, 5'd8, 12);
    start_run(12);
    check("R4 addi positive", dmem[3], 32'd5000);
    check("R4 addi negative", dmem[2], 32'hFFFFFFFD);
    check("R5 add", dmem[0], 32'd4997);
    check("R5 sub", dmem[1], 32'(-5003));
  endtask

  task automatic test_mem;
    clear_mems();
    dmem[16] = 32'h12345678;
    imem[0] = ri(ADDI, 5'd0, 5'd14, 80);
    imem[1] = ri(LW, 5'd14, 5'd8, -16);
    imem[2] = rr(5'd8, 5'd8, 5'd9, F_ADD);
    imem[3] = ri(SW, 5'd14, 5'd9, 4);
    start_run(8);
    check("R3 lw negative offset then sw", dmem[21], 32'h2468ACF0);
    check("R3 source untouched", dmem[16], 32'h12345678);
  endtask

  task automatic test_slt;
    clear_mems();
    imem[0] = ri(ADDI, 5'd0, 5'd11, 9);
    imem[1] = ri(ADDI, 5'd0, 5'd12, 9);
    imem[2] = ri(ADDI, 5'd0, 5'd8, -1);
    imem[3] = ri(ADDI, 5'd0, 5'd9, 1);
    imem[4] = rr(5'd8, 5'd9, 5'd10, F_SLT);
    imem[5] = rr(5'd9, 5'd8, 5'd11, F_SLT);
    imem[6] = rr(5'd8, 5'd8, 5'd12, F_SLT);
    imem[7] = ri(SW, 5'd0, 5'd10, 0);
    imem[8] = ri(SW, 5'd0, 5'd11, 4);
    imem[9] = ri(SW, 5'd0, 5'd12, 8);
    start_run(14);
    check("R6 slt -1<1", dmem[0], 32'd1);
    check("R6 slt 1<-1", dmem[1], 32'd0);
    check("R6 slt equal", dmem[2], 32'd0);
  endtask

  task automatic test_mult;
    logic [63:0] big;
    big = 64'd70000 * 64'd70000;
    clear_mems();
    imem[0]  = ri(ADDI, 5'd0, 5'd8, 30000);
    imem[1]  = rr(5'd8, 5'd8, 5'd8, F_ADD);
    imem[2]  = ri(ADDI, 5'd8, 5'd8, 10000);
    imem[3]  = rr(5'd8, 5'd0, 5'd9, F_ADD);
    imem[4]  = ri(ADDI, 5'd0, 5'd10, 77);
    imem[5]  = rr(5'd8, 5'd9, 5'd10, F_MULT);
    imem[6]  = ri(SW, 5'd0, 5'd10, 0);
    imem[7]  = rr(5'd0, 5'd0, 5'd11, F_MFLO);
    imem[8]  = ri(SW, 5'd0, 5'd11, 4);
    imem[9]  = ri(ADDI, 5'd0, 5'd12, -7);
    imem[10] = rr(5'd12, 5'd8, 5'd0, F_MULT);
    imem[11] = rr(5'd0, 5'd0, 5'd13, F_MFLO);
    imem[12] = ri(SW, 5'd0, 5'd13, 8);
    start_run(16);
    check("R7 mult writes no gpr", dmem[0], 32'd77);
    check("R7 low product wraps", dmem[1], big[31:0]);
    check("R7 signed product", dmem[2], 32'(-490000));
  endtask

  task automatic test_branch;
    clear_mems();
    imem[0]  = ri(ADDI, 5'd0, 5'd8, 5);
    imem[1]  = ri(ADDI, 5'd0, 5'd9, 5);
    imem[2]  = ri(BEQ, 5'd8, 5'd9, 1);
    imem[3]  = ri(ADDI, 5'd0, 5'd10, 1);
    imem[4]  = ri(ADDI, 5'd0, 5'd11, 2);
    imem[5]  = ri(BNE, 5'd8, 5'd9, 1);
    imem[6]  = ri(ADDI, 5'd0, 5'd12, 3);
    imem[7]  = ri(ADDI, 5'd0, 5'd13, 0);
    imem[8]  = ri(ADDI, 5'd13, 5'd13, 1);
    imem[9]  = ri(BNE, 5'd13, 5'd8, -2);
    imem[10] = ri(SW, 5'd0, 5'd10, 0);
    imem[11] = ri(SW, 5'd0, 5'd11, 4);
    imem[12] = ri(SW, 5'd0, 5'd12, 8);
    imem[13] = ri(SW, 5'd0, 5'd13, 12);
    start_run(40);
    check("R8 beq taken skips", dmem[0], 32'd0);
    check("R8 target reached", dmem[1], 32'd2);
    check("R8 bne not taken", dmem[2], 32'd3);
    check("R8 backward loop count", dmem[3], 32'd5);
  endtask

  task automatic test_jump;
    clear_mems();
    imem[0]  = jj(JAL, 4);
    imem[1]  = ri(ADDI, 5'd0, 5'd10, 11);
    imem[2]  = jj(J, 7);
    imem[3]  = ri(ADDI, 5'd0, 5'd11, 99);
    imem[4]  = ri(ADDI, 5'd0, 5'd8, 22);
    imem[5]  = rr(5'd31, 5'd0, 5'd0, F_JR);
    imem[6]  = ri(ADDI, 5'd0, 5'd12, 55);
    imem[7]  = ri(SW, 5'd0, 5'd8, 0);
    imem[8]  = ri(SW, 5'd0, 5'd10, 4);
    imem[9]  = ri(SW, 5'd0, 5'd11, 8);
    imem[10] = ri(SW, 5'd0, 5'd12, 12);
    imem[11] = ri(SW, 5'd0, 5'd31, 16);
    start_run(14);
    check("R9 jal target executed", dmem[0], 32'd22);
    check("R10 jr returns", dmem[1], 32'd11);
    check("R9 j skips", dmem[2], 32'd0);
    check("R9 j lands on target", dmem[3], 32'd0);
    check("R9 jal link value", dmem[4], 32'd4);
  endtask

  task automatic test_zero;
    clear_mems();
    dmem[0] = 32'hAAAA5555;
    dmem[1] = 32'h00001234;
    dmem[2] = 32'hFFFFFFFF;
    imem[0] = ri(ADDI, 5'd0, 5'd0, 77);
    imem[1] = ri(LW, 5'd0, 5'd0, 4);
    imem[2] = ri(SW, 5'd0, 5'd0, 0);
    imem[3] = ri(ADDI, 5'd0, 5'd9, 3);
    imem[4] = rr(5'd9, 5'd9, 5'd0, F_ADD);
    imem[5] = rr(5'd0, 5'd9, 5'd10, F_ADD);
    imem[6] = ri(SW, 5'd0, 5'd0, 8);
    imem[7] = ri(SW, 5'd0, 5'd10, 12);
    start_run(12);
    check("R11 addi/lw to zero ignored", dmem[0], 32'd0);
    check("R11 add to zero ignored", dmem[2], 32'd0);
    check("R11 zero as operand", dmem[3], 32'd3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_arith();
    test_mem();
    test_slt();
    test_mult();
    test_branch();
    test_jump();
    test_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule